// File: doc/BRIEF.md
# Coalescing Store Buffer for a Write-Through Cache

This block sits between a write-through first-level cache and the next cache level. The processor can hand it one word store per cycle, which is faster than the next level can accept writes. Each entry holds one cache-block address, the block's data words and a per-word mask showing which words have been written. A store to a block that already has an open entry is folded into that entry, so several stores to one block leave as a single masked block write. Entries leave in the order they were opened. A block whose words have all been written goes out flagged as a full-line write, so the next level does not need to fetch the old line first.

The processor's read port looks into the buffer in the same cycle. When the requested word is held in the buffer, the newest copy is returned. The entry at the head of the queue is the one being offered downstream. A store that matches this entry opens a new entry, so the write already in flight is never changed.

Top module: `cwb_top`

## Requirements
- R1: After reset the buffer is empty: `dn_valid` is 0, `st_ready` is 1 and `rd_hit` is 0.
- R2: A word address splits into a block number (`st_addr >> log2(WORDS)`) and a word index (the low `log2(WORDS)` bits). While an entry is free, a store to a new block is accepted in the cycle it is presented. A burst of NUM_ENT stores to distinct blocks is accepted back to back with no stall.
- R3: A store whose block matches an open entry other than the head merges into that entry. It sets mask bit `w` and writes data bits `[w*DW +: DW]`, and no new entry is opened. A later store to the same word replaces the earlier value.
- R4: Entries are offered downstream in the order they were opened. A merge does not change an entry's place in that order.
- R5: `dn_valid` is 1 exactly when the buffer is not empty. While `dn_valid` is 1 and `dn_ready` is 0, `dn_blk`, `dn_data` and `dn_mask` hold steady. The head entry is removed on the cycle in which `dn_valid` and `dn_ready` are both 1.
- R6: `dn_full` is 1 when all WORDS mask bits of the offered entry are set. It marks a write that needs no fetch of the old line.
- R7: A partially written block goes out with mask bits set only for the words that were written. Data words whose mask bit is clear read as zero.
- R8: A read returns, in the same cycle, `rd_hit`=1 and the newest buffered value when some open entry holds that block with that word's mask bit set. Otherwise `rd_hit` is 0.
- R9: When all entries are open, a store that matches no non-head entry sees `st_ready`=0 and is not taken until an entry has drained. A store that can merge is still accepted while the buffer is full.
- R10: A store to the head entry's block opens a new entry, and the head's payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Processor store request |
| st_addr | input | AW | Word address of the store |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store accepted this cycle when high together with st_valid |
| rd_addr | input | AW | Word address of the processor read probe |
| rd_hit | output | 1 | The requested word is held in the buffer |
| rd_data | output | DW | Newest buffered value of that word |
| dn_valid | output | 1 | Head entry offered downstream |
| dn_ready | input | 1 | Next level takes the offered entry |
| dn_blk | output | AW-log2(WORDS) | Block number of the offered entry |
| dn_data | output | WORDS*DW | Block data, word i at bits [i*DW +: DW] |
| dn_mask | output | WORDS | Written-word mask, bit i for word i |
| dn_full | output | 1 | Every word of the offered block is written |

## Verification
The assertions assume that the next level follows valid/ready rules: it may hold `dn_ready` low for any number of cycles, and an offer is taken only on a cycle in which both signals are high. They also assume that a store is held with the same address and data until `st_ready` takes it. The bench drives all inputs on the falling edge. A stalled store is either re-presented unchanged or dropped before the next rising edge. Addresses are kept inside the default address width, so no block number wraps.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2,
    ACT_STALL = 2'd3
  } st_act_e;

  function automatic int unsigned ring_next(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/cwb_entry.sv
module cwb_entry #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  parameter int BAW   = 14,
  parameter int WIDX  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_i,
  input  logic                  merge_i,
  input  logic                  clear_i,
  input  logic                  is_head_i,
  input  logic [BAW-1:0]        wr_blk_i,
  input  logic [WIDX-1:0]       wr_word_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic [BAW-1:0]        rd_blk_i,
  input  logic [WIDX-1:0]       rd_word_i,
  output logic                  valid_o,
  output logic [BAW-1:0]        blk_o,
  output logic [WORDS*DW-1:0]   data_o,
  output logic [WORDS-1:0]      mask_o,
  output logic                  st_match_o,
  output logic                  rd_hit_o,
  output logic [DW-1:0]         rd_data_o
);

  logic                          valid_q;
  logic [BAW-1:0]                blk_q;
  logic [WORDS-1:0][DW-1:0]      data_q;
  logic [WORDS-1:0]              mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (clear_i) begin
        valid_q <= 1'b0;
        mask_q  <= '0;
      end
      if (alloc_i) begin
        valid_q           <= 1'b1;
        blk_q             <= wr_blk_i;
        data_q            <= '0;
        data_q[wr_word_i] <= wr_data_i;
        mask_q            <= '0;
        mask_q[wr_word_i] <= 1'b1;
      end else if (merge_i) begin
        data_q[wr_word_i] <= wr_data_i;
        mask_q[wr_word_i] <= 1'b1;
      end
    end
  end

  assign valid_o    = valid_q;
  assign blk_o      = blk_q;
  assign data_o     = data_q;
  assign mask_o     = mask_q;
  assign st_match_o = valid_q && !is_head_i && (blk_q == wr_blk_i);
  assign rd_hit_o   = valid_q && (blk_q == rd_blk_i) && mask_q[rd_word_i];
  assign rd_data_o  = data_q[rd_word_i];

  // R3: a merge only ever lands on an open entry
  p_merge_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    merge_i |-> valid_q);
  // R2: allocation only into a free slot (or one emptied the same cycle)
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (!valid_q || clear_i));
  // R10: the entry being drained is never written by a merge
  p_head_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_head_i && valid_q && !clear_i) |=> $stable(data_q) && $stable(mask_q));

endmodule

// File: rtl/cwb_order.sv
module cwb_order #(
  parameter int NUM_ENT = 4,
  parameter int PW      = 2,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [PW-1:0] head_o,
  output logic [PW-1:0] tail_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= PW'(cwb_pkg::ring_next(32'(tail_q), NUM_ENT));
      if (pop_i)  head_q <= PW'(cwb_pkg::ring_next(32'(head_q), NUM_ENT));
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (count_q == CW'(NUM_ENT));
  assign empty_o = (count_q == '0);

  // R9: no entry is opened while every slot is taken
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R5: a drain only happens from a non-empty buffer
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/cwb_fwd.sv
module cwb_fwd #(
  parameter int NUM_ENT = 4,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] hit_i,
  input  logic [NUM_ENT-1:0] head_oh_i,
  input  logic [DW-1:0]      data_i [NUM_ENT],
  output logic               hit_o,
  output logic [DW-1:0]      data_o
);

  logic [NUM_ENT-1:0] young_hit;

  assign young_hit = hit_i & ~head_oh_i;

  // A non-head match is always newer than the head, so it takes priority.
  always_comb begin
    hit_o  = |hit_i;
    data_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (hit_i[i] && head_oh_i[i]) data_o = data_i[i];
    end
    for (int i = 0; i < NUM_ENT; i++) begin
      if (young_hit[i]) data_o = data_i[i];
    end
  end

  // R8: at most one non-head copy of any word can exist
  p_single_young_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(young_hit));

endmodule

// File: rtl/cwb_top.sv
module cwb_top #(
  parameter int NUM_ENT = 4,
  parameter int WORDS   = 4,
  parameter int DW      = 32,
  parameter int AW      = 16,
  localparam int WIDX   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int BAW    = AW - WIDX
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                st_valid,
  input  logic [AW-1:0]       st_addr,
  input  logic [DW-1:0]       st_data,
  output logic                st_ready,
  input  logic [AW-1:0]       rd_addr,
  output logic                rd_hit,
  output logic [DW-1:0]       rd_data,
  output logic                dn_valid,
  input  logic                dn_ready,
  output logic [BAW-1:0]      dn_blk,
  output logic [WORDS*DW-1:0] dn_data,
  output logic [WORDS-1:0]    dn_mask,
  output logic                dn_full
);

  import cwb_pkg::*;

  localparam int PW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CW = $clog2(NUM_ENT + 1);

  function automatic logic [BAW-1:0] blk_of(logic [AW-1:0] a);
    return a[AW-1:WIDX];
  endfunction

  function automatic logic [WIDX-1:0] word_of(logic [AW-1:0] a);
    return a[WIDX-1:0];
  endfunction

  logic [PW-1:0]        head, tail;
  logic                 full, empty;
  logic [NUM_ENT-1:0]   ent_valid, st_match, rd_match, head_oh;
  logic [NUM_ENT-1:0]   alloc_vec, merge_vec, clear_vec;
  logic [BAW-1:0]       ent_blk  [NUM_ENT];
  logic [WORDS*DW-1:0]  ent_data [NUM_ENT];
  logic [WORDS-1:0]     ent_mask [NUM_ENT];
  logic [DW-1:0]        ent_rd   [NUM_ENT];
  st_act_e              act;

  // named events for the assertions
  logic ev_merge, ev_alloc, ev_stall, ev_drain;

  always_comb begin
    if (!st_valid)     act = ACT_IDLE;
    else if (|st_match) act = ACT_MERGE;
    else if (!full)    act = ACT_ALLOC;
    else               act = ACT_STALL;
  end

  assign ev_merge = (act == ACT_MERGE);
  assign ev_alloc = (act == ACT_ALLOC);
  assign ev_stall = (act == ACT_STALL);
  assign ev_drain = dn_valid && dn_ready;
  assign st_ready = (|st_match) || !full;

  generate
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      assign head_oh[i]   = !empty && (head == PW'(i));
      assign alloc_vec[i] = ev_alloc && (tail == PW'(i));
      assign merge_vec[i] = ev_merge && st_match[i];
      assign clear_vec[i] = ev_drain && (head == PW'(i));

      cwb_entry #(.DW(DW), .WORDS(WORDS), .BAW(BAW), .WIDX(WIDX)) u_ent (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_i   (alloc_vec[i]),
        .merge_i   (merge_vec[i]),
        .clear_i   (clear_vec[i]),
        .is_head_i (head_oh[i]),
        .wr_blk_i  (blk_of(st_addr)),
        .wr_word_i (word_of(st_addr)),
        .wr_data_i (st_data),
        .rd_blk_i  (blk_of(rd_addr)),
        .rd_word_i (word_of(rd_addr)),
        .valid_o   (ent_valid[i]),
        .blk_o     (ent_blk[i]),
        .data_o    (ent_data[i]),
        .mask_o    (ent_mask[i]),
        .st_match_o(st_match[i]),
        .rd_hit_o  (rd_match[i]),
        .rd_data_o (ent_rd[i])
      );
    end
  endgenerate

  cwb_order #(.NUM_ENT(NUM_ENT), .PW(PW), .CW(CW)) u_order (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (ev_alloc),
    .pop_i  (ev_drain),
    .head_o (head),
    .tail_o (tail),
    .full_o (full),
    .empty_o(empty)
  );

  cwb_fwd #(.NUM_ENT(NUM_ENT), .DW(DW)) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (rd_match),
    .head_oh_i(head_oh),
    .data_i   (ent_rd),
    .hit_o    (rd_hit),
    .data_o   (rd_data)
  );

  assign dn_valid = !empty;
  assign dn_blk   = ent_blk[head];
  assign dn_data  = ent_data[head];
  assign dn_mask  = ent_mask[head];
  assign dn_full  = &ent_mask[head];

  // R5: an offer not taken stays valid and unchanged
  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> dn_valid && $stable(dn_blk) && $stable(dn_data)
                                && $stable(dn_mask));
  // R9: a store is refused only while every slot is occupied
  p_stall_only_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |-> (&ent_valid));
  // R3: one store touches at most one entry
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec | merge_vec));
  // R7: an offered entry always carries at least one written word
  p_mask_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_mask != '0));
  // R1: buffer is empty on the first cycle out of reset
  p_reset_empty_r1: assert property (@(posedge clk)
    !rst_n |=> !dn_valid);

endmodule

// File: tb/cwb_top_tb_top.sv
module cwb_top_tb_top;

  localparam int NE = 4, NW = 4, DW = 32, AW = 16, BAW = 14;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              st_valid;
  logic [AW-1:0]     st_addr;
  logic [DW-1:0]     st_data;
  logic              st_ready;
  logic [AW-1:0]     rd_addr;
  logic              rd_hit;
  logic [DW-1:0]     rd_data;
  logic              dn_valid;
  logic              dn_ready;
  logic [BAW-1:0]    dn_blk;
  logic [NW*DW-1:0]  dn_data;
  logic [NW-1:0]     dn_mask;
  logic              dn_full;

  always #5 clk = ~clk;

  cwb_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_blk(dn_blk),
    .dn_data(dn_data), .dn_mask(dn_mask), .dn_full(dn_full)
  );

  typedef struct {
    logic [BAW-1:0]   blk;
    logic [NW*DW-1:0] data;
    logic [NW-1:0]    mask;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  task automatic check(bit ok, string req, string what,
                       logic [NW*DW-1:0] act, logic [NW*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // index of a non-head model entry holding the block, -1 if none
  function automatic int young_match(logic [BAW-1:0] b);
    for (int j = 1; j < exp_q.size(); j++)
      if (exp_q[j].blk == b) return j;
    return -1;
  endfunction

  function automatic bit model_ready(logic [AW-1:0] a);
    return (young_match(a[AW-1:2]) >= 0) || (exp_q.size() < NE);
  endfunction

  task automatic model_store(logic [AW-1:0] a, logic [DW-1:0] d);
    int   j;
    exp_t e;
    j = young_match(a[AW-1:2]);
    if (j >= 0) begin
      exp_q[j].data[a[1:0]*DW +: DW] = d;
      exp_q[j].mask[a[1:0]] = 1'b1;
    end else begin
      e.blk  = a[AW-1:2];
      e.data = '0;
      e.data[a[1:0]*DW +: DW] = d;
      e.mask = '0;
      e.mask[a[1:0]] = 1'b1;
      exp_q.push_back(e);
    end
  endtask

  // monitor: compares the downstream offer and store acceptance, then
  // advances the model and the clock by one cycle
  task automatic tick();
    bit acc, pop;
    #1;
    check(dn_valid == (exp_q.size() != 0), "R5", "dn_valid", dn_valid, exp_q.size() != 0);
    if (st_valid)
      check(st_ready == model_ready(st_addr), "R9", "st_ready", st_ready, model_ready(st_addr));
    if (dn_valid && exp_q.size() != 0) begin
      check(dn_blk == exp_q[0].blk, "R4", "dn_blk", dn_blk, exp_q[0].blk);
      check(dn_mask == exp_q[0].mask, "R7", "dn_mask", dn_mask, exp_q[0].mask);
      check(dn_data == exp_q[0].data, "R3", "dn_data", dn_data, exp_q[0].data);
      check(dn_full == (&exp_q[0].mask), "R6", "dn_full", dn_full, &exp_q[0].mask);
    end
    acc = st_valid && st_ready;
    pop = dn_valid && dn_ready;
    if (acc) model_store(st_addr, st_data);
    if (pop && exp_q.size() != 0) void'(exp_q.pop_front());
    @(posedge clk);
    @(negedge clk);
  endtask

  // driver: present one store; wait for acceptance or give up after one cycle
  task automatic store(logic [AW-1:0] a, logic [DW-1:0] d, bit wait_acc, output bit took);
    st_valid = 1'b1; st_addr = a; st_data = d;
    took = 1'b0;
    forever begin
      #1;
      took = st_ready;
      tick();
      if (took || !wait_acc) break;
    end
    st_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic bit model_read(logic [AW-1:0] a, output logic [DW-1:0] v);
    for (int j = exp_q.size() - 1; j >= 0; j--)
      if (exp_q[j].blk == a[AW-1:2] && exp_q[j].mask[a[1:0]]) begin
        v = exp_q[j].data[a[1:0]*DW +: DW];
        return 1'b1;
      end
    v = '0;
    return 1'b0;
  endfunction

  task automatic probe(logic [AW-1:0] a, string req);
    logic [DW-1:0] v;
    bit h;
    rd_addr = a;
    #1;
    h = model_read(a, v);
    check(rd_hit == h, req, "rd_hit", rd_hit, h);
    if (h) check(rd_data == v, req, "rd_data", rd_data, v);
  endtask

  function automatic logic [AW-1:0] wa(int blk, int w);
    return AW'(blk * NW + w);
  endfunction

  task automatic drain_all();
    dn_ready = 1'b1;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) tick();
    idle(1);
    check(!dn_valid, "R4", "drained", dn_valid, 0);
  endtask

  initial begin
    bit took;
    logic [BAW-1:0] held;
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
    rd_addr = '0; dn_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!dn_valid, "R1", "dn_valid", dn_valid, 0);
    check(st_ready, "R1", "st_ready", st_ready, 1);
    check(!rd_hit, "R1", "rd_hit", rd_hit, 0);

    // R2: four distinct blocks back to back, none refused
    for (int b = 1; b <= NE; b++) begin
      store(wa(b, 0), 32'h1000 + b, 1'b0, took);
      check(took, "R2", "burst accept", took, 1);
    end
    // R9: full but mergeable store is accepted; R3 merge and overwrite
    store(wa(2, 3), 32'hAAAA_0001, 1'b0, took);
    check(took, "R9", "merge while full", took, 1);
    store(wa(2, 3), 32'hAAAA_0002, 1'b0, took);
    check(took, "R3", "overwrite merge", took, 1);
    // R9: full and new block is refused
    store(wa(9, 0), 32'h9, 1'b0, took);
    check(!took, "R9", "stall new block", took, 0);
    // R10: full and head block is refused (head is not a merge target)
    store(wa(1, 1), 32'h11, 1'b0, took);
    check(!took, "R10", "head not merged", took, 0);
    // R8 probes
    probe(wa(2, 3), "R8");
    probe(wa(2, 1), "R8");
    probe(wa(5, 0), "R8");
    // R5: hold the offer for a few cycles
    held = dn_blk;
    idle(3);
    check(dn_blk == held, "R5", "held blk", dn_blk, held);
    drain_all();

    // R6: full line behind an unrelated head
    dn_ready = 1'b0;
    store(wa(8, 2), 32'h8, 1'b1, took);
    for (int w = 0; w < NW; w++) store(wa(7, w), 32'h7000 + w, 1'b1, took);
    probe(wa(7, 2), "R8");
    drain_all();

    // R10: head block store opens a new entry; newest copy is read back
    dn_ready = 1'b0;
    store(wa(5, 0), 32'hA, 1'b1, took);
    store(wa(5, 1), 32'hB, 1'b1, took);
    store(wa(5, 0), 32'hC, 1'b1, took);
    check(exp_q.size() == 2, "R10", "entries", exp_q.size(), 2);
    probe(wa(5, 0), "R8");
    probe(wa(5, 1), "R8");
    drain_all();

    // mixed stores and drains with a toggling ready pattern
    for (int i = 0; i < 40; i++) begin
      dn_ready = (i % 3) != 0;
      store(wa((i * 5) % 6, i % NW), 32'h5000 + i, 1'b1, took);
      probe(wa(i % 6, (i + 1) % NW), "R8");
    end
    drain_all();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule